// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block collects a bank of external interrupt request lines and steers each one, through its own programmable table entry, onto one bit of a small pending-vector register whose bits drive the processor's interrupt cause lines. Every entry decides whether its source is live, whether it is sensed as a level or as an edge, which sense counts as active, which vector bit it raises, and which hardware threads it targets. Only thread 0 exists here, so only bit 0 of the thread mask gates delivery.

Software programs the table and clears interrupts through one flat register port. Writes take effect on the clock edge and reads are combinational. Clearing happens at two levels. A per-source acknowledge releases a latched edge request. A per-vector write-one-to-clear drops a pending bit. Because many sources may share a vector, a vector bit rises again while any of its enabled sources is still requesting. Each input line passes through a two-flop synchronizer before any detection.

Top module: `irt_ctrl`

## Requirements
- R1: After reset every entry's control word reads 0 (invalid), every thread-mask word reads 1, the pending register reads 0 and the cause output is 0.
- R2: Source n's thread-mask word is at address 2n and its control word at 2n+1. The acknowledge register is at 64 and the pending register at 65. In the control word, bit 31 is valid, bit 30 is a stored local/global select, bit 29 is trigger (1 = level, 0 = edge), bit 28 is polarity (1 = active-low or falling edge), and bits 2:0 are the vector number. Both words read back what was written in these fields. Writing 0 to a control word leaves that source's mask word unchanged.
- R3: A valid level-triggered source requests while its synchronized input equals its active level: high when polarity is 0, low when polarity is 1.
- R4: A valid edge-triggered source latches a request on the selected edge of its synchronized input (rising when polarity is 0, falling when polarity is 1). The latch holds after the input returns and ignores the opposite edge.
- R5: Writing the acknowledge register with bit n set clears the latched edge request of source n. It has no effect on a level-triggered source.
- R6: A requesting source sets the pending bit equal to its vector number. The cause output equals the pending register.
- R7: Writing the pending register with bit v set clears pending bit v and leaves bits written 0 unchanged. The bit is set again on the next edge while any enabled source routed to v still requests, so with sources sharing a vector it stays set until all are cleared.
- R8: A source whose entry is invalid, or whose thread-mask bit 0 is clear, never sets a pending bit.
- R9: A level change on an input line reaches the cause output on the third rising clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 32 | Asynchronous interrupt request lines, one per source |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| cause_o | output | 8 | Pending vector bits presented as interrupt cause lines |

## Verification
The bench targets the two-level clear. A pending bit cleared while its edge latch is still held must come straight back. If the acknowledge cleared the pending bit, or the write-one-to-clear reached the latch, the interrupt would be lost or never release. Two edge sources on one vector are acknowledged one at a time, so a design that OR-ed only the last writer, or cleared the whole vector, shows the wrong cause value. The bench samples the synchronizer latency on the exact edge, which catches a missing or extra flop. It also drives an invalid source, a masked source and an opposite-polarity edge, where a design that skipped the gating or the polarity would raise a spurious cause bit.

// File: rtl/irt_pkg.sv
package irt_pkg;
    localparam int DATA_W    = 32;
    // control-word field positions
    localparam int HI_VALID  = 31;
    localparam int HI_LOCAL  = 30;
    localparam int HI_LEVEL  = 29;
    localparam int HI_LOW    = 28;
endpackage

// File: rtl/irt_sync.sv
module irt_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d.s1 = async_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign sync_o = q.s2;
endmodule

// File: rtl/irt_src_detect.sv
module irt_src_detect (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    input  logic valid_i,
    input  logic level_i,
    input  logic low_i,
    input  logic ack_i,
    output logic req_o
);
    typedef struct packed {
        logic prev;
        logic latch;
    } det_t;

    det_t d, q;
    logic edge_hit;

    always_comb begin
        edge_hit = low_i ? (q.prev & ~sync_i) : (~q.prev & sync_i);
        d.prev   = sync_i;
        if (!valid_i || level_i) d.latch = 1'b0;
        else if (edge_hit)       d.latch = 1'b1;
        else if (ack_i)          d.latch = 1'b0;
        else                     d.latch = q.latch;
        req_o = valid_i & (level_i ? (sync_i ^ low_i) : q.latch);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R4
    edge_latch_set_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !level_i && edge_hit) |=> (q.latch || !valid_i || level_i));

    // R5
    edge_ack_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !edge_hit) |=> !q.latch);
endmodule

// File: rtl/irt_route.sv
module irt_route #(
    parameter int NUM_SRC = 32,
    parameter int NUM_VEC = 8,
    parameter int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic [NUM_SRC-1:0]            req_i,
    input  logic [NUM_SRC-1:0]            en_i,
    input  logic [NUM_SRC-1:0][VEC_W-1:0] vec_i,
    output logic [NUM_VEC-1:0]            act_o
);
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        always_comb begin
            act_o[v] = 1'b0;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (req_i[s] && en_i[s] && (vec_i[s] == VEC_W'(v)))
                    act_o[v] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irt_ctrl.sv
module irt_ctrl #(
    parameter int NUM_SRC = 32,
    parameter int NUM_VEC = 8,
    parameter int MASK_W  = 4,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int ADDR_W = SRC_W + 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_SRC-1:0]          irq_i,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [irt_pkg::DATA_W-1:0]  cfg_wdata,
    output logic [irt_pkg::DATA_W-1:0]  cfg_rdata,
    output logic [NUM_VEC-1:0]          cause_o
);
    import irt_pkg::*;

    localparam logic [ADDR_W-1:0] ACK_ADDR  = ADDR_W'(2 * NUM_SRC);
    localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(2 * NUM_SRC + 1);

    typedef struct packed {
        logic [NUM_SRC-1:0]             valid;
        logic [NUM_SRC-1:0]             loc;
        logic [NUM_SRC-1:0]             lvl;
        logic [NUM_SRC-1:0]             low;
        logic [NUM_SRC-1:0][VEC_W-1:0]  vec;
        logic [NUM_SRC-1:0][MASK_W-1:0] mask;
        logic [NUM_VEC-1:0]             pend;
    } state_t;

    state_t d, q;

    logic [NUM_SRC-1:0] irq_sync;
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] thr0_en;
    logic [NUM_SRC-1:0] ack_mask;
    logic [NUM_VEC-1:0] w1c_mask;
    logic [NUM_VEC-1:0] act_vec;
    logic [NUM_VEC-1:0] keep;
    logic               is_entry;
    logic [SRC_W-1:0]   idx;

    assign is_entry = (cfg_addr[ADDR_W-1] == 1'b0);
    assign idx      = cfg_addr[SRC_W:1];
    assign ack_mask = (cfg_we && cfg_addr == ACK_ADDR)  ? cfg_wdata[NUM_SRC-1:0] : '0;
    assign w1c_mask = (cfg_we && cfg_addr == PEND_ADDR) ? cfg_wdata[NUM_VEC-1:0] : '0;
    assign keep     = q.pend & ~w1c_mask;

    irt_sync #(.W(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (irq_i),
        .sync_o  (irq_sync)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        irt_src_detect u_det (
            .clk     (clk),
            .rst     (rst),
            .sync_i  (irq_sync[s]),
            .valid_i (q.valid[s]),
            .level_i (q.lvl[s]),
            .low_i   (q.low[s]),
            .ack_i   (ack_mask[s]),
            .req_o   (req[s])
        );
        assign thr0_en[s] = q.mask[s][0];
    end

    irt_route #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_route (
        .req_i (req),
        .en_i  (thr0_en),
        .vec_i (q.vec),
        .act_o (act_vec)
    );

    // next-state
    always_comb begin
        d = q;
        if (cfg_we && is_entry) begin
            if (cfg_addr[0]) begin
                d.valid[idx] = cfg_wdata[HI_VALID];
                d.loc[idx]   = cfg_wdata[HI_LOCAL];
                d.lvl[idx]   = cfg_wdata[HI_LEVEL];
                d.low[idx]   = cfg_wdata[HI_LOW];
                d.vec[idx]   = cfg_wdata[VEC_W-1:0];
            end else begin
                d.mask[idx]  = cfg_wdata[MASK_W-1:0];
            end
        end
        d.pend = keep | act_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.valid <= '0;
            q.loc   <= '0;
            q.lvl   <= '0;
            q.low   <= '0;
            q.vec   <= '0;
            for (int s = 0; s < NUM_SRC; s++) q.mask[s] <= MASK_W'(1);
            q.pend  <= '0;
        end else begin
            q <= d;
        end
    end

    // read mux
    always_comb begin
        cfg_rdata = '0;
        if (is_entry) begin
            if (cfg_addr[0]) begin
                cfg_rdata[HI_VALID]  = q.valid[idx];
                cfg_rdata[HI_LOCAL]  = q.loc[idx];
                cfg_rdata[HI_LEVEL]  = q.lvl[idx];
                cfg_rdata[HI_LOW]    = q.low[idx];
                cfg_rdata[VEC_W-1:0] = q.vec[idx];
            end else begin
                cfg_rdata[MASK_W-1:0] = q.mask[idx];
            end
        end else if (cfg_addr == PEND_ADDR) begin
            cfg_rdata[NUM_VEC-1:0] = q.pend;
        end
    end

    assign cause_o = q.pend;

    // R1
    pend_reset_chk: assert property (@(posedge clk)
        rst |=> (q.pend == '0));

    // R6
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|act_vec) |=> ((cause_o & $past(act_vec)) == $past(act_vec)));

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (|keep) |=> ((q.pend & $past(keep)) == $past(keep)));
endmodule

// File: tb/sim_irt_ctrl.sv
`timescale 1ns/1ps
module sim_irt_ctrl;
    localparam int ACK  = 64;
    localparam int PEND = 65;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq = '0;
    logic        we = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  cause;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    irt_ctrl u0 (
        .clk(clk), .rst(rst), .irq_i(irq), .cfg_we(we), .cfg_addr(addr),
        .cfg_wdata(wdata), .cfg_rdata(rdata), .cause_o(cause)
    );

    function automatic logic [31:0] hiw(input logic v, input logic lvl,
                                        input logic low, input logic [2:0] vec);
        return {v, 1'b1, lvl, low, 25'd0, vec};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        we = 1'b1; addr = 7'(a); wdata = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        addr = 7'(a);
        #1 v = rdata;
    endtask

    task automatic cleanup();
        irq = '0;
        for (int s = 0; s < 32; s++) wr(2*s+1, 32'd0);
        cyc(4);
        wr(ACK, 32'hFFFF_FFFF);
        wr(PEND, 32'hFF);
        cyc(1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1, v);    chk("R1 hi0", v, 32'd0);
        rd(62, v);   chk("R1 lo31", v, 32'd1);
        rd(PEND, v); chk("R1 pend", v, 32'd0);
        chk("R1 cause", {24'd0, cause}, 32'd0);
        irq[0] = 1'b1; cyc(5);
        chk("R8 invalid src", {24'd0, cause}, 32'd0);
        irq[0] = 1'b0; cyc(3);
    endtask

    task automatic t_level();
        wr(9, hiw(1, 1, 0, 3));
        @(negedge clk); irq[4] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9 not before 3rd edge", {24'd0, cause}, 32'd0);
        @(negedge clk);
        chk("R9 R3 R6 level high", {24'd0, cause}, 32'h08);
        wr(ACK, 32'h10); cyc(1);
        chk("R5 ack ignored for level", {24'd0, cause}, 32'h08);
        wr(PEND, 32'h08); cyc(1);
        chk("R7 reset while active", {24'd0, cause}, 32'h08);
        irq[4] = 1'b0; cyc(4);
        chk("R6 pend held after drop", {24'd0, cause}, 32'h08);
        wr(PEND, 32'h08);
        chk("R7 w1c clears", {24'd0, cause}, 32'h00);
        wr(9, hiw(1, 1, 1, 3)); cyc(2);
        chk("R3 active low", {24'd0, cause}, 32'h08);
        irq[4] = 1'b1; cyc(4);
        wr(PEND, 32'h08);
        chk("R3 active low idle", {24'd0, cause}, 32'h00);
        cleanup();
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(19, hiw(1, 0, 0, 1));
        @(negedge clk); irq[9] = 1'b1;
        @(negedge clk); irq[9] = 1'b0;
        cyc(6);
        chk("R4 rising latched", {24'd0, cause}, 32'h02);
        wr(PEND, 32'h02); cyc(1);
        chk("R4 latch held past w1c", {24'd0, cause}, 32'h02);
        wr(PEND, 32'h01); cyc(1);
        chk("R7 zero bits unchanged", {24'd0, cause}, 32'h02);
        wr(ACK, 32'h0000_0200); cyc(1);
        chk("R5 ack keeps pend", {24'd0, cause}, 32'h02);
        wr(PEND, 32'h02);
        rd(PEND, v);
        chk("R5 cleared after ack", v, 32'd0);
        wr(21, hiw(1, 0, 1, 6));
        irq[10] = 1'b1; cyc(6);
        chk("R4 falling ignores rise", {24'd0, cause}, 32'h00);
        irq[10] = 1'b0; cyc(6);
        chk("R4 falling latched", {24'd0, cause}, 32'h40);
        cleanup();
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(20, 32'h5);
        wr(21, hiw(1, 1, 0, 4));
        rd(21, v); chk("R2 hi readback", v, hiw(1, 1, 0, 4));
        wr(21, 32'd0);
        rd(20, v); chk("R2 lo kept after disable", v, 32'h5);
        rd(21, v); chk("R2 hi zero", v, 32'd0);
        irq[10] = 1'b1; cyc(6);
        chk("R8 disabled src", {24'd0, cause}, 32'h00);
        wr(20, 32'h1);
        cleanup();
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(24, 32'hA);
        rd(24, v); chk("R2 lo readback", v, 32'hA);
        wr(25, hiw(1, 1, 0, 2));
        irq[12] = 1'b1; cyc(6);
        chk("R8 thread0 masked", {24'd0, cause}, 32'h00);
        wr(24, 32'hB); cyc(1);
        chk("R8 thread0 enabled", {24'd0, cause}, 32'h04);
        wr(24, 32'h1);
        cleanup();
    endtask

    task automatic t_shared();
        logic [31:0] v;
        wr(41, hiw(1, 0, 0, 5));
        wr(43, hiw(1, 0, 0, 5));
        @(negedge clk); irq[20] = 1'b1; irq[21] = 1'b1;
        @(negedge clk); irq[20] = 1'b0; irq[21] = 1'b0;
        cyc(6);
        chk("R6 shared vec", {24'd0, cause}, 32'h20);
        wr(ACK, 32'h0010_0000);
        wr(PEND, 32'h20); cyc(1);
        chk("R7 shared still held", {24'd0, cause}, 32'h20);
        wr(ACK, 32'h0020_0000);
        wr(PEND, 32'h20);
        rd(PEND, v);
        chk("R7 shared cleared", v, 32'd0);
        cleanup();
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_level();
        t_edge();
        t_disable();
        t_mask();
        t_shared();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule